// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synthesizable model of a synchronous, pipelined static memory that serves short bursts. Every input (address, control strobes and write data) is captured on the rising clock edge. An access then runs in the following cycle, and read data sits in an output register one clock after its address was captured. The array holds 2^AW words, each split into byte lanes (four lanes of nine bits by default). A write can update every lane at once, or only the lanes that a per-lane mask selects.

A burst opens through one of two start strobes. The host-side strobe always makes a read and only counts while the chip is selected. The controller-side strobe makes a read or a write, and while the chip is not selected it ends the burst instead. Three select inputs must all be high for the chip to count as selected, so several devices can share one address space. While a burst is open, cycles without a start continue it. On such a cycle the advance input steps the two low address bits in linear or interleaved order, and without advance the same word is accessed again. The shared data bus is modelled as a data output plus a drive flag. The flag is high only when the output register holds read data and output enable is asserted.

Top module: `psram_burst`

## Requirements
- R1: After reset the drive flag is low and no burst is open, so cycles with no start strobe perform no access and the drive flag stays low.
- R2: A read whose address is captured at clock edge k drives its data after edge k+1 and not before. A write cycle captured at edge k leaves the drive flag low after edge k+1.
- R3: With `oe` low, `rdata_vld` is 0 and `rdata` is all zeros. Raising `oe` while the output register holds read data drives that data without waiting for a clock edge.
- R4: A start strobe counts only when `sel_a`, `sel_b` and `sel_c` are all high. A host start with any select low makes no access, and a controller start with any select low writes nothing.
- R5: A controller start with any select low closes the open burst. The drive flag is low after the second edge following it, and later continuation cycles make no access.
- R6: When both start strobes are high and the chip is selected, the host start wins and the cycle is a read. `wr_all`, `wr_lanes_en` and `lane_wr` are ignored on that cycle.
- R7: A write with `wr_all` high updates all lanes of the word, whatever `wr_lanes_en` and `lane_wr` hold.
- R8: With `wr_all` low and `wr_lanes_en` high, lane i (bits `9i+8:9i`) is written only when `lane_wr[i]` is 1. The other lanes keep their contents.
- R9: With `wr_all` and `wr_lanes_en` both low, the cycle is a read even if `lane_wr` is nonzero.
- R10: With `order_sel` = 0 (linear), each advance cycle accesses the word whose low two address bits are (start low bits + count) mod 4, where count is the number of advances since the start. The upper address bits keep their start value, and the count wraps after four steps.
- R11: With `order_sel` = 1 (interleaved), the low two address bits are (start low bits XOR count). The upper bits and the wrap behave as in R10.
- R12: A continuation cycle with `burst_adv` low accesses the same word as the previous access of the burst.
- R13: A write to a word followed in the next cycle by a read of that word returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| start_host | input | 1 | Host-side burst start (read) |
| start_ctl | input | 1 | Controller-side burst start, or burst end when deselected |
| burst_adv | input | 1 | Step the burst address on a continuation cycle |
| wr_all | input | 1 | Write every lane |
| wr_lanes_en | input | 1 | Enable per-lane writes from `lane_wr` |
| lane_wr | input | LANES | Per-lane write mask |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data |
| oe | input | 1 | Output enable |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rdata_vld | output | 1 | Bus-driven flag |

## Verification
The hardest state to reach from the ports is the address wrap inside a burst, with the two burst orders diverging. Reaching it needs a start address whose low bits are neither 0 nor 2, since for those two values linear and interleaved order give the same sequence. The bench starts at a word with low bits 01 and advances four times in each order, so every step and the return to the start word are seen. A second hard-to-reach point is the deselect that lands in the middle of a burst. The bench opens a burst, issues a controller start with one select low, and then keeps pulsing advance, so that any residual access would show up on the drive flag.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low two address bits for a given burst step.
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORDER_INTERLEAVE) r = base ^ cnt;
    else                         r = 2'(base + cnt);
    return r;
  endfunction

endpackage

// File: rtl/psram_cycle_dec.sv
module psram_cycle_dec #(
  parameter int LANES = 4
) (
  input  logic             start_host,
  input  logic             start_ctl,
  input  logic             burst_adv,
  input  logic             wr_all,
  input  logic             wr_lanes_en,
  input  logic [LANES-1:0] lane_wr,
  input  logic             sel_a,
  input  logic             sel_b,
  input  logic             sel_c,
  input  logic             burst_open,
  output logic             load,
  output logic             step,
  output logic             close,
  output logic             acc,
  output logic             wr,
  output logic [LANES-1:0] lanes
);

  logic chip_on;
  logic host_go;
  logic ctl_go;
  logic cont;
  logic wr_req;

  always_comb begin
    chip_on = sel_a & sel_b & sel_c;
    host_go = start_host & chip_on;
    ctl_go  = start_ctl & chip_on & ~host_go;
    load    = host_go | ctl_go;
    close   = start_ctl & ~chip_on;
    cont    = burst_open & ~start_ctl & ~host_go;
    step    = cont & burst_adv;
    acc     = load | cont;
    wr_req  = wr_all | (wr_lanes_en & (|lane_wr));
    wr      = acc & ~host_go & wr_req;
    if (wr_all)           lanes = '1;
    else if (wr_lanes_en) lanes = lane_wr;
    else                  lanes = '0;
  end

endmodule

// File: rtl/psram_burst_seq.sv
module psram_burst_seq
  import psram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          close,
  input  burst_order_e  order,
  input  logic [AW-1:0] addr_in,
  output logic          burst_open,
  output logic [AW-1:0] cur_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic          open_q;
  logic [1:0]    cnt_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= 2'd0;
        open_q <= 1'b1;
      end else begin
        if (step)  cnt_q  <= 2'(cnt_q + 2'd1);
        if (close) open_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cnt_use = step ? 2'(cnt_q + 2'd1) : cnt_q;
    if (load) cur_addr = addr_in;
    else      cur_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_use, order)};
  end

  assign burst_open = open_q;

  // R10 / R11: an advance moves the burst count by exactly one
  a_r10_step_count: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R12: without advance or start, the burst position does not move
  a_r12_hold_position: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> ($stable(cnt_q) && $stable(base_q)));

  // R5: a deselecting controller start closes the burst
  a_r5_burst_closed: assert property (@(posedge clk) disable iff (rst)
    (close && !load) |=> !open_q);

endmodule

// File: rtl/psram_lane_array.sv
module psram_lane_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc_i,
  input  logic                    wr_i,
  input  logic [LANES-1:0]        lanes_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);

  localparam int DEPTH = 1 << AW;

  logic rd_en;
  assign rd_en = acc_i & ~wr_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (acc_i && wr_i && lanes_i[l])
        mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (rd_en)
        rd_q <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_o <= 1'b0;
    else     rvalid_o <= rd_en;
  end

  // R2: a captured read fills the output register on the next edge
  a_r2_read_lands: assert property (@(posedge clk) disable iff (rst)
    (acc_i && !wr_i) |=> rvalid_o);

  // R2: a write cycle leaves the output register empty
  a_r2_write_idle: assert property (@(posedge clk) disable iff (rst)
    (acc_i && wr_i) |=> !rvalid_o);

  // R8: a write always names at least one lane
  a_r8_lanes_named: assert property (@(posedge clk) disable iff (rst)
    (acc_i && wr_i) |-> (lanes_i != '0));

endmodule

// File: rtl/psram_burst.sv
module psram_burst
  import psram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    order_sel,
  input  logic                    sel_a,
  input  logic                    sel_b,
  input  logic                    sel_c,
  input  logic                    start_host,
  input  logic                    start_ctl,
  input  logic                    burst_adv,
  input  logic                    wr_all,
  input  logic                    wr_lanes_en,
  input  logic [LANES-1:0]        lane_wr,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_vld
);

  localparam int DW = LANES * LANE_W;

  logic             load, step, close, acc, wr, burst_open;
  logic [LANES-1:0] lanes;
  logic [AW-1:0]    cur_addr;

  logic             s1_acc, s1_wr;
  logic [LANES-1:0] s1_lanes;
  logic [AW-1:0]    s1_addr;
  logic [DW-1:0]    s1_wdata;

  logic [DW-1:0]    arr_rdata;
  logic             arr_rvalid;

  psram_cycle_dec #(.LANES(LANES)) u_dec (
    .start_host (start_host),
    .start_ctl  (start_ctl),
    .burst_adv  (burst_adv),
    .wr_all     (wr_all),
    .wr_lanes_en(wr_lanes_en),
    .lane_wr    (lane_wr),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .sel_c      (sel_c),
    .burst_open (burst_open),
    .load       (load),
    .step       (step),
    .close      (close),
    .acc        (acc),
    .wr         (wr),
    .lanes      (lanes)
  );

  psram_burst_seq #(.AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .close     (close),
    .order     (burst_order_e'(order_sel)),
    .addr_in   (addr),
    .burst_open(burst_open),
    .cur_addr  (cur_addr)
  );

  // Input capture stage
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_acc   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_lanes <= '0;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_acc   <= acc;
      s1_wr    <= wr;
      s1_lanes <= lanes;
      s1_addr  <= cur_addr;
      s1_wdata <= wdata;
    end
  end

  psram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk     (clk),
    .rst     (rst),
    .acc_i   (s1_acc),
    .wr_i    (s1_wr),
    .lanes_i (s1_lanes),
    .addr_i  (s1_addr),
    .wdata_i (s1_wdata),
    .rdata_o (arr_rdata),
    .rvalid_o(arr_rvalid)
  );

  assign rdata_vld = arr_rvalid & oe;
  assign rdata     = rdata_vld ? arr_rdata : '0;

  // R4: with no burst open, an unselected cycle captures no access
  a_r4_unselected_idle: assert property (@(posedge clk) disable iff (rst)
    (!burst_open && !(sel_a && sel_b && sel_c)) |=> !s1_acc);

  // R6: a selected host start is never captured as a write
  a_r6_host_reads: assert property (@(posedge clk) disable iff (rst)
    (start_host && sel_a && sel_b && sel_c) |=> !s1_wr);

  // R7: a selected controller write with the all-lanes input covers every lane
  a_r7_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (start_ctl && !start_host && wr_all && sel_a && sel_b && sel_c)
      |=> (s1_wr && (&s1_lanes)));

  // R5: the bus is idle two edges after a deselecting controller start
  a_r5_bus_idle: assert property (@(posedge clk) disable iff (rst)
    (start_ctl && !(sel_a && sel_b && sel_c)) |=> ##1 !rdata_vld);

endmodule

// File: tb/sim_psram_burst.sv
module sim_psram_burst;
  localparam int AW = 6, LANES = 4, LW = 9, DW = LANES * LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, order_sel, sel_a, sel_b, sel_c, start_host, start_ctl;
  logic burst_adv, wr_all, wr_lanes_en, oe;
  logic [LANES-1:0] lane_wr;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata, rdata;
  logic             rdata_vld;

  psram_burst #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .order_sel(order_sel), .sel_a(sel_a), .sel_b(sel_b),
    .sel_c(sel_c), .start_host(start_host), .start_ctl(start_ctl),
    .burst_adv(burst_adv), .wr_all(wr_all), .wr_lanes_en(wr_lanes_en),
    .lane_wr(lane_wr), .addr(addr), .wdata(wdata), .oe(oe),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  logic [DW-1:0] ref_mem [DEPTH];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  function automatic logic [DW-1:0] pat(input int a);
    return {6'(a) ^ 6'h2B, 30'(a * 9973 + 517)};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    start_host = 0; start_ctl = 0; burst_adv = 0; wr_all = 0; wr_lanes_en = 0;
    lane_wr = '0; sel_a = 1; sel_b = 1; sel_c = 1;
  endtask

  task automatic check(input string tag, input logic v_exp, input logic [DW-1:0] d_exp);
    n_chk++;
    if (rdata_vld !== v_exp || rdata !== d_exp) begin
      n_bad++;
      $display("FAIL %s: vld=%b data=%h expected vld=%b data=%h",
               tag, rdata_vld, rdata, v_exp, d_exp);
    end
  endtask

  task automatic deselect();
    idle(); start_ctl = 1; sel_a = 0; tick(); idle();
  endtask

  task automatic rd_start(input int a);
    idle(); start_host = 1; addr = AW'(a); tick();
  endtask

  task automatic wr_start(input int a, input logic [DW-1:0] d, input logic g,
                          input logic b, input logic [LANES-1:0] m);
    idle(); start_ctl = 1; addr = AW'(a); wdata = d; wr_all = g; wr_lanes_en = b;
    lane_wr = m;
    for (int i = 0; i < LANES; i++)
      if (g || (b && m[i])) ref_mem[a][i*LW +: LW] = d[i*LW +: LW];
    tick();
  endtask

  task automatic t_reset();
    rst = 1; idle(); oe = 1; order_sel = 0; addr = '0; wdata = '0;
    repeat (3) tick();
    rst = 0;
    check("R1 reset", 0, '0);
    idle(); burst_adv = 1; tick();
    check("R1 no burst", 0, '0);
    tick();
    check("R1 no burst", 0, '0);
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) wr_start(a, pat(a), 1, 0, '0);
    deselect(); tick();
  endtask

  task automatic t_latency();
    rd_start(5);
    check("R2 not early", 0, '0);
    rd_start(9);
    check("R2 read 5", 1, ref_mem[5]);
    deselect();
    check("R2 read 9", 1, ref_mem[9]);
  endtask

  task automatic t_oe();
    oe = 0;
    rd_start(12);
    deselect();
    check("R3 oe low", 0, '0);
    oe = 1; #1;
    check("R3 oe high", 1, ref_mem[12]);
    tick();
  endtask

  task automatic t_selects();
    for (int i = 0; i < 3; i++) begin
      deselect(); tick();
      idle(); start_host = 1; addr = AW'(3);
      if (i == 0) sel_a = 0; else if (i == 1) sel_b = 0; else sel_c = 0;
      tick(); idle(); tick();
      check("R4 host unselected", 0, '0);
    end
    deselect();
    idle(); start_ctl = 1; wr_all = 1; sel_c = 0; addr = AW'(3); wdata = '0;
    tick(); idle(); tick();
    check("R4 ctl unselected", 0, '0);
    rd_start(3); deselect();
    check("R4 no write", 1, ref_mem[3]);
  endtask

  task automatic t_close();
    order_sel = 0;
    rd_start(17);
    idle(); burst_adv = 1; tick();
    check("R5 before close", 1, ref_mem[17]);
    idle(); start_ctl = 1; sel_b = 0; tick();
    check("R5 last read", 1, ref_mem[18]);
    idle(); burst_adv = 1; tick();
    check("R5 bus idle", 0, '0);
    tick();
    check("R5 burst closed", 0, '0);
    idle();
  endtask

  task automatic t_host_prio();
    idle(); start_host = 1; start_ctl = 1; wr_all = 1; wr_lanes_en = 1; lane_wr = '1;
    addr = AW'(30); wdata = ~ref_mem[30];
    tick();
    deselect();
    check("R6 host read", 1, ref_mem[30]);
    rd_start(30); deselect();
    check("R6 no write", 1, ref_mem[30]);
  endtask

  task automatic t_raw();
    wr_start(20, 36'h9_8765_4321, 1, 0, '0);
    rd_start(20);
    check("R2 write idle", 0, '0);
    deselect();
    check("R13 new data", 1, ref_mem[20]);
  endtask

  task automatic t_lanes();
    wr_start(40, 36'hA_BCDE_F012, 0, 1, 4'b0101);
    rd_start(40); deselect();
    check("R8 lanes 0,2", 1, ref_mem[40]);
    wr_start(41, 36'h1_2345_6789, 0, 1, 4'b1000);
    rd_start(41); deselect();
    check("R8 lane 3", 1, ref_mem[41]);
  endtask

  task automatic t_global();
    wr_start(42, 36'h5_5AA5_A55A, 1, 1, 4'b0001);
    rd_start(42); deselect();
    check("R7 with mask", 1, ref_mem[42]);
    wr_start(44, 36'hC_3C3C_3C3C, 1, 0, 4'b0000);
    rd_start(44); deselect();
    check("R7 no mask", 1, ref_mem[44]);
  endtask

  task automatic t_no_enable();
    wr_start(43, 36'hF_FFFF_FFFF, 0, 0, 4'b1111);
    deselect();
    check("R9 acts as read", 1, ref_mem[43]);
    rd_start(43); deselect();
    check("R9 unchanged", 1, ref_mem[43]);
  endtask

  task automatic run_burst(input string tag, input logic ord, input int e0,
                           input int e1, input int e2, input int e3);
    order_sel = ord;
    rd_start(29);
    idle(); burst_adv = 1;
    tick(); check(tag, 1, ref_mem[29]);
    tick(); check(tag, 1, ref_mem[e1]);
    tick(); check(tag, 1, ref_mem[e2]);
    tick(); check(tag, 1, ref_mem[e3]);
    deselect(); check(tag, 1, ref_mem[e0]);
    order_sel = 0;
  endtask

  task automatic t_hold();
    order_sel = 0;
    rd_start(50);
    idle(); tick(); check("R12 hold", 1, ref_mem[50]);
    tick();         check("R12 hold", 1, ref_mem[50]);
    burst_adv = 1; tick(); check("R12 then adv", 1, ref_mem[50]);
    deselect();     check("R12 stepped", 1, ref_mem[51]);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_latency();
    t_oe();
    t_selects();
    t_close();
    t_host_prio();
    t_raw();
    t_lanes();
    t_global();
    t_no_enable();
    run_burst("R10 linear", 1'b0, 29, 30, 31, 28);
    run_burst("R11 interleave", 1'b1, 29, 28, 31, 30);
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: all requirements, run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule